// File: doc/BRIEF.md
# Remote Terminal Mode-Code Status Unit

This block holds the small set of status and control state that a serial-bus remote terminal keeps next to its protocol engine. It has a host-owned alternate self-test word, a sticky flag that records whether the terminal-flag status bit has been suppressed, and a copy of the terminal's address/parity field with a parity checker. The protocol engine decodes mode commands elsewhere. It hands this unit single-cycle strobes for three of them: suppress the terminal flag, cancel that suppression, and send the self-test word.

The host reaches the unit through a flat register port with combinational read data. Address 0 holds the alternate self-test word and is read/write. Address 1 is the status word and is read-only. Address 2 is the address/parity field and is read-only. Every other address reads as zero.

There are two reset sources with different reach. The hard reset clears everything and samples the address pins. The soft terminal reset clears only the suppression flag. When the send-self-test strobe arrives, an option input selects the source of the response word. With the option at 1, the word comes from the host register, and one cycle after the response a buffer-write strobe copies the same word out. With the option at 0, the response uses an internally supplied word and no buffer write follows.

Top module: `rt_modecode_status`

## Requirements
- R1: The word at host address 0 is written by a host write to address 0 and reads back the written value on the next cycle. The hard reset `mrst` clears it to 0.
- R2: The soft reset `srst` leaves the address-0 word unchanged. It clears the suppression flag.
- R3: A `mc19_bit` pulse in cycle T gives `resp_vld` = 1 in cycle T+1, and only then. With `alt_sel` = 1 in cycle T, `resp_word` equals the address-0 word as it stood in cycle T.
- R4: When the response in R3 came from the host word, `buf_wr` is 1 in cycle T+2 and `buf_data` equals that response word.
- R5: With `alt_sel` = 0 in cycle T, `resp_word` equals `int_bit_word` from cycle T. `buf_wr` stays 0 and the address-0 word is unchanged.
- R6: A `mc6_inh` pulse sets the suppression flag (status bit 0) and drives `tf_en` low. A `mc7_ovr` pulse clears the flag and raises `tf_en`. If both arrive in the same cycle, `mc7_ovr` wins.
- R7: The address/parity field uses odd parity over all 6 bits. `par_fail`, which also appears as status bit 1, is 1 exactly when the field holds an even number of ones.
- R8: While `mrst` is high, the field (address 2, bits 5:0) loads from `addr_pins`. An `init_ld` pulse overwrites it with `init_field`.
- R9: Host writes to addresses 1 and 2 change neither the status word nor the field.
- R10: If a host write to address 0 lands in the same cycle as `mc19_bit`, the response carries the old word and the new word reads back on the next cycle.
- R11: After hard reset, `tf_en` = 1, the status word is 0 for a field with odd parity, and `resp_vld` and `buf_wr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Hard master reset, synchronous, active high |
| srst | input | 1 | Soft terminal reset, synchronous, active high |
| host_wr | input | 1 | Host write enable |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from host_addr |
| mc6_inh | input | 1 | Strobe: suppress terminal flag |
| mc7_ovr | input | 1 | Strobe: cancel terminal-flag suppression |
| mc19_bit | input | 1 | Strobe: send self-test word |
| alt_sel | input | 1 | Option: 1 takes the response from the host word |
| int_bit_word | input | 16 | Internally generated self-test word |
| addr_pins | input | 6 | Address/parity pins, sampled during hard reset |
| init_ld | input | 1 | Auto-initialization load strobe for the field |
| init_field | input | 6 | Field value supplied by auto-initialization |
| tf_en | output | 1 | Terminal-flag enable |
| inh_flag | output | 1 | Suppression flag |
| par_fail | output | 1 | Address parity failure |
| resp_vld | output | 1 | Response word valid |
| resp_word | output | 16 | Response mode data word |
| buf_wr | output | 1 | Buffer write strobe |
| buf_data | output | 16 | Word to be written to the buffer |

## Verification
The checker watches several relations on every cycle:
- the override and suppress strobes, including their priority, and their effect on `tf_en` one cycle later;
- the response strobe's exact one-cycle latency;
- that a buffer write only ever follows a response;
- that the host word moves only on a host write to its address;
- that the parity flag moves only on a field load.

The values themselves need the bench's scenarios. These include:
- which source a response word came from;
- the old-versus-new word on a colliding write;
- parity across all 64 field values, loaded both through reset and through the load strobe;
- that writes to read-only addresses have no effect.

// File: rtl/rt_modecode_status.sv
module rt_modecode_status #(
  parameter int WW = 16,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          srst,
  input  logic          host_wr,
  input  logic [1:0]    host_addr,
  input  logic [WW-1:0] host_wdata,
  output logic [WW-1:0] host_rdata,
  input  logic          mc6_inh,
  input  logic          mc7_ovr,
  input  logic          mc19_bit,
  input  logic          alt_sel,
  input  logic [WW-1:0] int_bit_word,
  input  logic [FW-1:0] addr_pins,
  input  logic          init_ld,
  input  logic [FW-1:0] init_field,
  output logic          tf_en,
  output logic          inh_flag,
  output logic          par_fail,
  output logic          resp_vld,
  output logic [WW-1:0] resp_word,
  output logic          buf_wr,
  output logic [WW-1:0] buf_data
);

  logic [WW-1:0] alt_q;
  logic [FW-1:0] fld_q;
  logic          inh_q;
  logic          resp_alt_q;

  always_ff @(posedge clk) begin
    if (mrst) begin
      alt_q      <= '0;
      inh_q      <= 1'b0;
      fld_q      <= addr_pins;
      resp_vld   <= 1'b0;
      resp_word  <= '0;
      resp_alt_q <= 1'b0;
      buf_wr     <= 1'b0;
      buf_data   <= '0;
    end else begin
      if (host_wr && host_addr == 2'd0) alt_q <= host_wdata;
      if (srst || mc7_ovr) inh_q <= 1'b0;
      else if (mc6_inh)    inh_q <= 1'b1;
      if (init_ld) fld_q <= init_field;
      resp_vld   <= mc19_bit;
      if (mc19_bit) resp_word <= alt_sel ? alt_q : int_bit_word;
      resp_alt_q <= mc19_bit & alt_sel;
      buf_wr     <= resp_alt_q;
      if (resp_alt_q) buf_data <= resp_word;
    end
  end

  assign inh_flag = inh_q;
  assign tf_en    = ~inh_q;
  assign par_fail = ~(^fld_q);

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = alt_q;
      2'd1:    host_rdata = {{(WW-2){1'b0}}, par_fail, inh_q};
      2'd2:    host_rdata = {{(WW-FW){1'b0}}, fld_q};
      default: host_rdata = '0;
    endcase
  end

endmodule

module rt_modecode_status_chk #(
  parameter int WW = 16
) (
  input logic          clk,
  input logic          mrst,
  input logic          srst,
  input logic          host_wr,
  input logic [1:0]    host_addr,
  input logic          mc6_inh,
  input logic          mc7_ovr,
  input logic          mc19_bit,
  input logic          alt_sel,
  input logic          init_ld,
  input logic [WW-1:0] alt_q,
  input logic          tf_en,
  input logic          par_fail,
  input logic          resp_vld,
  input logic          buf_wr
);

  // R6
  ovr_wins_chk: assert property (@(posedge clk) disable iff (mrst)
    mc7_ovr |=> tf_en);

  // R6
  inh_sets_chk: assert property (@(posedge clk) disable iff (mrst)
    (mc6_inh && !mc7_ovr && !srst) |=> !tf_en);

  // R3
  resp_follow_chk: assert property (@(posedge clk) disable iff (mrst)
    mc19_bit |=> resp_vld);

  // R3
  resp_only_chk: assert property (@(posedge clk) disable iff (mrst)
    !mc19_bit |=> !resp_vld);

  // R4
  buf_after_resp_chk: assert property (@(posedge clk) disable iff (mrst)
    buf_wr |-> $past(resp_vld));

  // R5
  no_buf_int_chk: assert property (@(posedge clk) disable iff (mrst)
    (mc19_bit && !alt_sel) |=> ##1 !buf_wr);

  // R2
  alt_keep_chk: assert property (@(posedge clk) disable iff (mrst)
    !(host_wr && host_addr == 2'd0) |=> $stable(alt_q));

  // R7
  par_stable_chk: assert property (@(posedge clk) disable iff (mrst)
    !init_ld |=> $stable(par_fail));

endmodule

bind rt_modecode_status rt_modecode_status_chk #(.WW(WW)) u_chk (
  .clk(clk), .mrst(mrst), .srst(srst), .host_wr(host_wr), .host_addr(host_addr),
  .mc6_inh(mc6_inh), .mc7_ovr(mc7_ovr), .mc19_bit(mc19_bit), .alt_sel(alt_sel),
  .init_ld(init_ld), .alt_q(alt_q), .tf_en(tf_en), .par_fail(par_fail),
  .resp_vld(resp_vld), .buf_wr(buf_wr)
);

// File: tb/rt_modecode_status_tb.sv
module rt_modecode_status_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic        mrst, srst, host_wr, mc6_inh, mc7_ovr, mc19_bit, alt_sel, init_ld;
  logic [1:0]  host_addr;
  logic [15:0] host_wdata, host_rdata, int_bit_word, resp_word, buf_data;
  logic [5:0]  addr_pins, init_field;
  logic        tf_en, inh_flag, par_fail, resp_vld, buf_wr;

  int checks = 0, errors = 0;
  bit done = 0;

  rt_modecode_status u_dut (
    .clk(clk), .mrst(mrst), .srst(srst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mc6_inh(mc6_inh), .mc7_ovr(mc7_ovr),
    .mc19_bit(mc19_bit), .alt_sel(alt_sel), .int_bit_word(int_bit_word),
    .addr_pins(addr_pins), .init_ld(init_ld), .init_field(init_field), .tf_en(tf_en),
    .inh_flag(inh_flag), .par_fail(par_fail), .resp_vld(resp_vld), .resp_word(resp_word),
    .buf_wr(buf_wr), .buf_data(buf_data));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick(); host_wr = 0;
  endtask

  task automatic hard_reset(logic [5:0] pins);
    addr_pins = pins; mrst = 1; tick(); tick(); mrst = 0;
  endtask

  function automatic logic exp_par(logic [5:0] v);
    return ($countones(v) % 2) == 0;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, oldw;
    mrst = 0; srst = 0; host_wr = 0; mc6_inh = 0; mc7_ovr = 0; mc19_bit = 0;
    alt_sel = 0; init_ld = 0; host_addr = 0; host_wdata = 0; int_bit_word = 16'hC3A5;
    addr_pins = 6'b000001; init_field = 0;
    #2;
    hard_reset(6'b000001);
    // R11 reset state
    check("R11 tf_en", tf_en, 1);
    check("R11 resp_vld", resp_vld, 0);
    check("R11 buf_wr", buf_wr, 0);
    rd(1, d); check("R11 status", d, 0);
    rd(0, d); check("R1 reset word", d, 0);

    // R1 write/read sweep over walking ones and patterns
    for (int i = 0; i < 16; i++) begin
      wr(0, 16'h1 << i); rd(0, d); check("R1 walk", d, 16'h1 << i);
    end
    for (int i = 0; i < 64; i++) begin
      logic [15:0] v = 16'(i * 1031 + 7);
      wr(0, v); rd(0, d); check("R1 pattern", d, v);
    end

    // R2 soft reset keeps word, clears inhibit
    wr(0, 16'hBEEF);
    mc6_inh = 1; tick(); mc6_inh = 0;
    check("R6 inhibit tf_en", tf_en, 0);
    rd(1, d); check("R6 status bit0", d[0], 1);
    srst = 1; tick(); srst = 0;
    rd(0, d); check("R2 word kept", d, 16'hBEEF);
    check("R2 inhibit cleared", inh_flag, 0);

    // R6 all strobe combinations
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        logic exp_inh;
        mc6_inh = (s == 1); tick(); mc6_inh = 0;
        mc6_inh = c[0]; mc7_ovr = c[1]; tick(); mc6_inh = 0; mc7_ovr = 0;
        exp_inh = c[1] ? 1'b0 : (c[0] ? 1'b1 : (s == 1));
        check("R6 flag", inh_flag, exp_inh);
        check("R6 tf_en", tf_en, !exp_inh);
      end
    end

    // R3 R4 host-sourced response
    wr(0, 16'h5A17);
    alt_sel = 1; mc19_bit = 1; tick(); mc19_bit = 0; alt_sel = 0;
    check("R3 resp_vld", resp_vld, 1);
    check("R3 resp_word", resp_word, 16'h5A17);
    check("R4 buf_wr early", buf_wr, 0);
    tick();
    check("R3 resp_vld drop", resp_vld, 0);
    check("R4 buf_wr", buf_wr, 1);
    check("R4 buf_data", buf_data, 16'h5A17);
    tick();
    check("R4 buf_wr single", buf_wr, 0);

    // R5 internal source
    alt_sel = 0; mc19_bit = 1; tick(); mc19_bit = 0;
    check("R5 resp_vld", resp_vld, 1);
    check("R5 resp_word", resp_word, 16'hC3A5);
    tick();
    check("R5 no buf_wr", buf_wr, 0);
    rd(0, d); check("R5 word kept", d, 16'h5A17);

    // R10 collision
    oldw = 16'h5A17;
    alt_sel = 1; mc19_bit = 1; host_wr = 1; host_addr = 0; host_wdata = 16'h9001;
    tick(); mc19_bit = 0; host_wr = 0; alt_sel = 0;
    check("R10 old in resp", resp_word, oldw);
    rd(0, d); check("R10 new readable", d, 16'h9001);
    tick();
    check("R10 buf old", buf_data, oldw);

    // R9 read-only addresses ignore writes
    init_field = 6'b000111; init_ld = 1; tick(); init_ld = 0;
    wr(1, 16'hFFFF); wr(2, 16'h0000);
    rd(2, d); check("R9 field kept", d, 16'h0007);
    rd(1, d); check("R9 status kept", d, {14'b0, exp_par(6'b000111), inh_flag});

    // R7 R8 parity sweep via init load
    for (int v = 0; v < 64; v++) begin
      init_field = 6'(v); init_ld = 1; tick(); init_ld = 0;
      rd(2, d); check("R8 init load", d, 16'(v));
      check("R7 par_fail", par_fail, exp_par(6'(v)));
      rd(1, d); check("R7 status bit1", d[1], exp_par(6'(v)));
    end
    // R8 R7 sweep via reset pins
    for (int v = 0; v < 64; v++) begin
      hard_reset(6'(v));
      addr_pins = ~6'(v); tick();
      rd(2, d); check("R8 pins", d, 16'(v));
      check("R7 par_fail pins", par_fail, exp_par(6'(v)));
      rd(0, d); check("R1 cleared", d, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule